// File: doc/BRIEF.md
# UART Interrupt Flag and Vector Unit

This block collects the status events of a UART-style serial port into a set of sticky flags. Each flag has an interrupt enable. A single interrupt line is raised while any enabled flag is pending. A 5-bit vector register names the most urgent pending enabled flag. Software reads the vector to find out what to service. The read also clears the flag it returned, so the next read reports the next pending source. The receive-ready and transmit-ready flags are the exception: a vector read leaves them set, and only their own data-path events clear them.

A break detector watches the sampled receive level. After a framing error (a missing stop bit), it counts bit ticks while the line stays low. When ten bit times pass with the line low, it sets the break flag. If the line returns high before then, the count is abandoned, and only a new framing error starts it again. A low period produces at most one break flag.

Flag bit `i` is reported as vector offset `i+1`, and offset 0 means nothing is pending. The lowest offset always wins. Software accesses the unit through a small register port with three addresses: flags at 0, enables at 1 and the vector at 2. Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged.

Top module: `uart_irq_vector_unit`

## Requirements
- R1: After reset, the flags, enables, vector and interrupt line are all zero.
- R2: A one-cycle pulse on `evt_i[i]` for `i` from 1 to NUM_FLAGS-1 sets flag `i` one clock later. The flag stays set after the pulse ends. `evt_i[0]` has no effect, because flag 0 is the break flag and only the break detector sets it.
- R3: A write to address 0 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Flags 8 (transmit ready) and 9 (receive ready) are not affected by such a write.
- R4: `vector_o` and a read of address 2 return `i+1` for the lowest index `i` whose flag and enable are both 1, or 0 when no such index exists. Disabled flags are never reported.
- R5: A read of address 2 that returns a nonzero offset other than 9 or 10 clears the flag at bit offset-1. From the next cycle, the vector shows the next pending enabled flag.
- R6: A read of address 2 that returns offset 9 or 10 leaves flags 8 and 9 set. A pulse on `tx_clr_i` clears flag 8, and a pulse on `rx_clr_i` clears flag 9.
- R7: After a `frame_err_i` pulse, the tenth `bit_tick_i` with `rx_i` low sets flag 0. The ninth tick does not.
- R8: `rx_i` high while counting abandons the break count. A later framing error restarts the count from zero. Ticks with `rx_i` low and no preceding framing error never set flag 0.
- R9: Once the break flag has been set and cleared, further low ticks in the same low period do not set it again.
- R10: `irq_o` is 1 exactly when some flag and its enable are both 1, including the break flag.
- R11: A `soft_rst_i` pulse clears all flags and the break detector, and keeps the enables.
- R12: A read of address 2 returns zero in bits 31:5. A write to address 2 changes neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Synchronous clear of flags and break detector |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| rx_i | input | 1 | Sampled receive line level |
| frame_err_i | input | 1 | Pulse: missing stop bit detected |
| evt_i | input | NUM_FLAGS | Event pulses that set flags |
| rx_clr_i | input | 1 | Receive data-path event clearing flag 9 |
| tx_clr_i | input | 1 | Transmit data-path event clearing flag 8 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0 flags, 1 enables, 2 vector) |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, combinational from address |
| flags_o | output | NUM_FLAGS | Flag register |
| vector_o | output | VEC_W | Current vector offset |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench sets two ordinary flags at a time and drains them with successive vector reads. This shows whether the priority order is honoured and whether each read clears only its own flag. It repeats the reads with the transmit and receive flags to separate protected bits from ordinary ones. It also changes the enable mask so that a disabled flag with higher priority has to be skipped.

The break detector gets three kinds of low periods:
- exactly nine and then ten ticks after a framing error, to expose an off-by-one in the count;
- a count broken by a high level and then restarted, which tells a restarted count from one that kept running;
- a long low period after the flag was cleared, which tells one flag per low period from repeated setting.

// File: rtl/uivu_pkg.sv
package uivu_pkg;
  localparam int BIT_BRK = 0;
  localparam int BIT_TX  = 8;
  localparam int BIT_RX  = 9;

  typedef enum logic [1:0] {
    ADDR_FLAGS  = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_VECTOR = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/uivu_brk_detect.sv
module uivu_brk_detect #(
  parameter int BRK_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic bit_tick_i,
  input  logic rx_i,
  input  logic frame_err_i,
  output logic brk_pulse_o
);
  localparam int CW = $clog2(BRK_BITS) + 1;
  localparam logic [CW-1:0] LAST = CW'(BRK_BITS - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick   = armed_q && !rx_i && bit_tick_i && (cnt_q == LAST);
  assign brk_pulse_o = last_tick && !frame_err_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (soft_rst_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (frame_err_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (rx_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (bit_tick_i) begin
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uivu_flag_bank.sv
module uivu_flag_bank #(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst_i,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_o <= '0;
    else if (soft_rst_i) flags_o <= '0;
    else                 flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/uivu_prio.sv
module uivu_prio #(
  parameter int NUM_FLAGS = 16,
  parameter int VEC_W     = 5
) (
  input  logic [NUM_FLAGS-1:0] pend_i,
  output logic [VEC_W-1:0]     vector_o
);
  function automatic logic [VEC_W-1:0] lowest_offset(input logic [NUM_FLAGS-1:0] v);
    logic [VEC_W-1:0] off;
    off = '0;
    for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
      if (v[i]) off = VEC_W'(i + 1);
    end
    return off;
  endfunction

  assign vector_o = lowest_offset(pend_i);
endmodule

// File: rtl/uart_irq_vector_unit.sv
module uart_irq_vector_unit
  import uivu_pkg::*;
#(
  parameter int NUM_FLAGS = 16,
  parameter int VEC_W     = 5,
  parameter int DATA_W    = 32,
  parameter int BRK_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst_i,
  input  logic                 bit_tick_i,
  input  logic                 rx_i,
  input  logic                 frame_err_i,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 rx_clr_i,
  input  logic                 tx_clr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic                 irq_o
);
  localparam logic [NUM_FLAGS-1:0] ONE     = NUM_FLAGS'(1);
  localparam logic [NUM_FLAGS-1:0] PROTECT = (ONE << BIT_RX) | (ONE << BIT_TX);
  localparam logic [NUM_FLAGS-1:0] BRK_M   = ONE << BIT_BRK;

  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] pend;
  logic [NUM_FLAGS-1:0] set_v, clr_v, vrd_clr, w1c_clr, dp_clr;
  logic                 brk_pulse;
  logic                 vec_rd;
  logic                 flag_wr;
  logic                 en_wr;

  assign vec_rd  = reg_rd_i && (reg_addr_i == ADDR_VECTOR);
  assign flag_wr = reg_wr_i && (reg_addr_i == ADDR_FLAGS);
  assign en_wr   = reg_wr_i && (reg_addr_i == ADDR_ENABLE);

  uivu_brk_detect #(.BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .bit_tick_i(bit_tick_i), .rx_i(rx_i), .frame_err_i(frame_err_i),
    .brk_pulse_o(brk_pulse)
  );

  always_comb begin
    for (int i = 0; i < NUM_FLAGS; i++) begin
      vrd_clr[i] = vec_rd && (vector_o == VEC_W'(i + 1)) && !PROTECT[i];
    end
    dp_clr         = '0;
    dp_clr[BIT_RX] = rx_clr_i;
    dp_clr[BIT_TX] = tx_clr_i;
  end

  assign w1c_clr = flag_wr ? (wr_data_i[NUM_FLAGS-1:0] & ~PROTECT) : '0;
  assign clr_v   = vrd_clr | w1c_clr | dp_clr;
  assign set_v   = (evt_i & ~BRK_M) | (brk_pulse ? BRK_M : '0);

  uivu_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .set_i(set_v), .clr_i(clr_v), .flags_o(flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wr_data_i[NUM_FLAGS-1:0];
  end

  assign pend  = flags_o & en_q;
  assign irq_o = |pend;

  uivu_prio #(.NUM_FLAGS(NUM_FLAGS), .VEC_W(VEC_W)) u_prio (
    .pend_i(pend), .vector_o(vector_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_FLAGS:  rd_data_o = DATA_W'(flags_o);
      ADDR_ENABLE: rd_data_o = DATA_W'(en_q);
      ADDR_VECTOR: rd_data_o = DATA_W'(vector_o);
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/uivu_chk.sv
module uivu_chk #(
  parameter int NUM_FLAGS = 16,
  parameter int VEC_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 soft_rst_i,
  input logic                 rx_i,
  input logic                 bit_tick_i,
  input logic                 rx_clr_i,
  input logic                 tx_clr_i,
  input logic                 vec_rd,
  input logic                 brk_pulse,
  input logic [NUM_FLAGS-1:0] evt_i,
  input logic [NUM_FLAGS-1:0] en_q,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [VEC_W-1:0]     vector_o,
  input logic                 irq_o
);
  localparam logic [NUM_FLAGS-1:0] ONE = NUM_FLAGS'(1);

  // R4
  vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o != '0) |-> ((flags_o & en_q & (ONE << (vector_o - 1'b1))) != '0));

  // R4
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o != '0) |-> ((flags_o & en_q & ((ONE << (vector_o - 1'b1)) - ONE)) == '0));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vector_o != '0));

  // R5
  vread_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vector_o != '0 && vector_o != VEC_W'(9) && vector_o != VEC_W'(10)
     && evt_i == '0 && !brk_pulse)
    |=> ((flags_o & (ONE << ($past(vector_o) - 1'b1))) == '0));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_o[9]) |-> $past(rx_clr_i || soft_rst_i));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_o[8]) |-> $past(tx_clr_i || soft_rst_i));

  // R7
  brk_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> (!rx_i && bit_tick_i));

  // R7
  brk_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && !soft_rst_i) |=> flags_o[0]);
endmodule

bind uart_irq_vector_unit uivu_chk #(.NUM_FLAGS(NUM_FLAGS), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .rx_i(rx_i),
  .bit_tick_i(bit_tick_i), .rx_clr_i(rx_clr_i), .tx_clr_i(tx_clr_i),
  .vec_rd(vec_rd), .brk_pulse(brk_pulse), .evt_i(evt_i), .en_q(en_q),
  .flags_o(flags_o), .vector_o(vector_o), .irq_o(irq_o)
);

// File: tb/uart_irq_vector_unit_tb.sv
module uart_irq_vector_unit_tb;
  localparam int NF = 16;
  localparam int VW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 0, bit_tick_i = 0, rx_i = 1, frame_err_i = 0;
  logic [NF-1:0] evt_i = '0;
  logic rx_clr_i = 0, tx_clr_i = 0, reg_wr_i = 0, reg_rd_i = 0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [NF-1:0] flags_o;
  logic [VW-1:0] vector_o;
  logic irq_o;

  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  uart_irq_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .bit_tick_i(bit_tick_i),
    .rx_i(rx_i), .frame_err_i(frame_err_i), .evt_i(evt_i), .rx_clr_i(rx_clr_i),
    .tx_clr_i(tx_clr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .flags_o(flags_o), .vector_o(vector_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [NF-1:0] m);
    evt_i = m; cyc(); evt_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a; wr_data_i = d; reg_wr_i = 1; cyc(); reg_wr_i = 0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; reg_rd_i = 1; #1 d = rd_data_o; cyc(); reg_rd_i = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1 d = rd_data_o;
  endtask

  task automatic tick();
    bit_tick_i = 1; cyc(); bit_tick_i = 0; cyc();
  endtask

  task automatic ferr();
    frame_err_i = 1; cyc(); frame_err_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", "flags", 32'(flags_o), 0);
    check("R1", "vector", 32'(vector_o), 0);
    check("R1", "irq", 32'(irq_o), 0);
    peek(2'd1, d);
    check("R1", "enables", d, 0);
  endtask

  task automatic t_set();
    pulse_evt(16'h0008);
    check("R2", "flag3 set", 32'(flags_o), 32'h0008);
    cyc();
    pulse_evt(16'h0020);
    check("R2", "sticky plus flag5", 32'(flags_o), 32'h0028);
    pulse_evt(16'h0001);
    check("R2", "evt0 ignored", 32'(flags_o), 32'h0028);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    check("R4", "no enables -> vector 0", 32'(vector_o), 0);
    check("R10", "no enables -> irq 0", 32'(irq_o), 0);
    wr(2'd1, 32'hFFFF);
    check("R4", "vector lowest", 32'(vector_o), 4);
    check("R10", "irq up", 32'(irq_o), 1);
    wr(2'd1, 32'hFFF7);
    peek(2'd2, d);
    check("R4", "disabled flag3 skipped", d, 6);
    wr(2'd1, 32'hFFFF);
  endtask

  task automatic t_w1c();
    wr(2'd0, 32'h0);
    check("R3", "write 0 no effect", 32'(flags_o), 32'h0028);
    wr(2'd0, 32'h0008);
    check("R3", "w1c bit3", 32'(flags_o), 32'h0020);
    wr(2'd0, 32'h0020);
    check("R3", "w1c bit5", 32'(flags_o), 0);
  endtask

  task automatic t_vread();
    logic [31:0] d;
    pulse_evt(16'h0024);
    rd(2'd2, d);
    check("R5", "first read offset", d, 3);
    check("R5", "flag2 cleared", 32'(flags_o), 32'h0020);
    check("R5", "next vector", 32'(vector_o), 6);
    rd(2'd2, d);
    check("R5", "second read offset", d, 6);
    check("R5", "all drained", 32'(flags_o), 0);
    check("R10", "irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    pulse_evt(16'h0300);
    rd(2'd2, d);
    check("R6", "tx offset", d, 9);
    check("R6", "tx/rx kept after read", 32'(flags_o), 32'h0300);
    wr(2'd0, 32'h0300);
    check("R3", "w1c ignores tx/rx", 32'(flags_o), 32'h0300);
    tx_clr_i = 1; cyc(); tx_clr_i = 0;
    check("R6", "tx_clr clears flag8", 32'(flags_o), 32'h0200);
    rd(2'd2, d);
    check("R6", "rx offset", d, 10);
    check("R6", "rx kept after read", 32'(flags_o), 32'h0200);
    rx_clr_i = 1; cyc(); rx_clr_i = 0;
    check("R6", "rx_clr clears flag9", 32'(flags_o), 0);
  endtask

  task automatic t_break();
    logic [31:0] d;
    rx_i = 0; cyc();
    ferr();
    for (int i = 0; i < 9; i++) tick();
    check("R7", "no break at 9 ticks", 32'(flags_o), 0);
    tick();
    check("R7", "break at 10 ticks", 32'(flags_o), 1);
    check("R10", "break raises irq", 32'(irq_o), 1);
    rd(2'd2, d);
    check("R5", "break offset read", d, 1);
    check("R5", "break cleared by read", 32'(flags_o), 0);
    for (int i = 0; i < 20; i++) tick();
    check("R9", "one break per low period", 32'(flags_o), 0);
    rx_i = 1; cyc();
  endtask

  task automatic t_restart();
    rx_i = 0; cyc();
    for (int i = 0; i < 12; i++) tick();
    check("R8", "no framing error no break", 32'(flags_o), 0);
    ferr();
    for (int i = 0; i < 5; i++) tick();
    rx_i = 1; cyc(); rx_i = 0; cyc();
    for (int i = 0; i < 10; i++) tick();
    check("R8", "high level abandons count", 32'(flags_o), 0);
    ferr();
    for (int i = 0; i < 5; i++) tick();
    rx_i = 1; cyc(); rx_i = 0;
    ferr();
    for (int i = 0; i < 9; i++) tick();
    check("R8", "restart from zero at 9", 32'(flags_o), 0);
    tick();
    check("R8", "restart break at 10", 32'(flags_o), 1);
    wr(2'd0, 32'h0001);
    check("R3", "w1c clears break", 32'(flags_o), 0);
    rx_i = 1; cyc();
  endtask

  task automatic t_soft();
    logic [31:0] d;
    pulse_evt(16'h0312);
    rx_i = 0; ferr(); tick(); tick();
    soft_rst_i = 1; cyc(); soft_rst_i = 0;
    check("R11", "flags cleared", 32'(flags_o), 0);
    peek(2'd1, d);
    check("R11", "enables kept", d, 32'h0000FFFF);
    for (int i = 0; i < 10; i++) tick();
    check("R11", "detector cleared", 32'(flags_o), 0);
    rx_i = 1; cyc();
  endtask

  task automatic t_vecreg();
    logic [31:0] d;
    pulse_evt(16'h8000);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R12", "vector write keeps flags", 32'(flags_o), 32'h8000);
    peek(2'd1, d);
    check("R12", "vector write keeps enables", d, 32'h0000FFFF);
    peek(2'd2, d);
    check("R12", "upper bits zero", d & 32'hFFFF_FFE0, 0);
    check("R4", "highest index offset", d, 16);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_set();
        t_vector();
        t_w1c();
        t_vread();
        t_protect();
        t_break();
        t_restart();
        t_soft();
        t_vecreg();
      end
      begin
        repeat (20000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule